// File: doc/BRIEF.md
# Byte-Stream Register Command Bridge

This block sits between a byte-wide host link and an on-chip register bus. The host sends a stream of bytes that the bridge packs into 32-bit words. Each command opens with a header word: the top byte selects the operation and the low 24 bits name a register. The bridge then runs a single register write, a single register read, or a pause measured in microseconds. After a read it sends the result back to the host as four bytes.

Only one command is in flight at a time. A read is finished only once all four reply bytes have left the output stream. A pause holds off the next command until the pause has run its course. A header carrying an opcode the bridge does not know stops the bridge for good. From then on it raises a flag, takes every incoming byte and throws it away, and does nothing more until it is reset. The bridge drives no other traffic of its own. The microsecond time base is derived from a clock-frequency parameter.

Top module: `bytecmd_bridge`

## Requirements
- R1: Every word travels as four bytes with the least significant byte first. This holds for incoming command words and for outgoing read data.
- R2: A header whose bits [31:24] equal 0x00 is followed by one data word. The bridge issues exactly one bus write of that word, to the address in header bits [23:0].
- R3: A header whose bits [31:24] equal 0x08 causes exactly one bus read of the address in bits [23:0]. The word read is returned on the output stream as four bytes.
- R4: A header whose bits [31:24] equal 0x01 is followed by a count word N. No bus request for the next command starts until N × (CLK_HZ / 1,000,000) clock cycles have passed. When N is 0 there is no wait.
- R5: A header with any other opcode sets `halted`. The flag stays set until reset. While it is set, `in_ready` is 1, input bytes are dropped, and no bus request or output byte appears.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values, so stalling the output loses no read data.
- R7: Once raised, a bus request keeps `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` unchanged until `bus_ready` completes it.
- R8: After reset `halted`, `bus_valid` and `out_valid` are 0 and `in_ready` is 1.
- R9: No bus request is made while reply bytes of a read are still waiting on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Bridge takes the input byte this cycle |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Consumer takes the output byte |
| bus_valid | output | 1 | Register bus request |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 24 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Request completes this cycle |
| bus_rdata | input | 32 | Read data, valid when a read completes |
| halted | output | 1 | Unknown opcode seen; stream processing stopped |

## Verification
The bench plays the bus slave and the output consumer. Both hand out their ready signals at random, so a bridge that lets a request or a byte change while it is stalled will lose or corrupt words. One pause is long and one has a zero count. These expose a time base that is off by a microsecond, or that blocks forever on zero. The output is held off while a second read is already queued. That catches a bridge that starts the next bus access, or overwrites the reply, before the first reply has gone out. An unknown opcode is followed by full write and read commands. A bridge that is not truly stopped would produce bus traffic or stall the link.

// File: rtl/bcb_pkg.sv
package bcb_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 24;
  localparam int OP_W   = WORD_W - ADDR_W;
  localparam int WORD_BYTES = WORD_W / BYTE_W;

  localparam logic [OP_W-1:0] OP_WRITE = 8'h00;
  localparam logic [OP_W-1:0] OP_DELAY = 8'h01;
  localparam logic [OP_W-1:0] OP_READ  = 8'h08;

  typedef enum logic [2:0] {
    ST_HDR, ST_WDATA, ST_DDATA, ST_BUSW, ST_BUSR, ST_SEND, ST_WAIT, ST_HALT
  } bcb_state_e;
endpackage

// File: rtl/bcb_word_asm.sv
module bcb_word_asm #(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    byte_valid,
  input  logic [BYTE_W-1:0]       byte_data,
  output logic                    byte_ready,
  output logic                    word_valid,
  output logic [BYTES*BYTE_W-1:0] word_data,
  input  logic                    word_take
);
  localparam int CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic                    full_q, full_d;
  logic [BYTES*BYTE_W-1:0] data_q, data_d;
  logic                    accept;

  assign accept     = byte_valid && !full_q;
  assign byte_ready = !full_q;
  assign word_valid = full_q;
  assign word_data  = data_q;

  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    data_d = data_q;
    if (word_take) full_d = 1'b0;
    if (accept) begin
      data_d[cnt_q*BYTE_W +: BYTE_W] = byte_data;
      if (cnt_q == CNT_W'(BYTES-1)) begin
        cnt_d  = '0;
        full_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
      if (accept) data_q <= data_d;
    end
  end
endmodule

// File: rtl/bcb_byte_ser.sv
module bcb_byte_ser #(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [BYTES*BYTE_W-1:0] load_word,
  output logic                    busy,
  output logic                    out_valid,
  output logic [BYTE_W-1:0]       out_data,
  input  logic                    out_ready
);
  localparam int LEFT_W = $clog2(BYTES + 1);

  logic [BYTES*BYTE_W-1:0] sh_q, sh_d;
  logic [LEFT_W-1:0]       left_q, left_d;
  logic                    shift_en;

  assign busy      = (left_q != '0);
  assign out_valid = busy;
  assign out_data  = sh_q[BYTE_W-1:0];
  assign shift_en  = out_valid && out_ready;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      sh_d   = load_word;
      left_d = LEFT_W'(BYTES);
    end else if (shift_en) begin
      sh_d   = sh_q >> BYTE_W;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load || shift_en) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/bcb_usec_timer.sv
module bcb_usec_timer #(
  parameter int CLK_HZ = 200_000_000,
  parameter int CNT_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_us,
  output logic             busy
);
  localparam int TICKS = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PRE_W = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] us_q, us_d;

  assign busy = (us_q != '0);

  always_comb begin
    pre_d = pre_q;
    us_d  = us_q;
    if (load) begin
      us_d  = load_us;
      pre_d = PRE_W'(TICKS-1);
    end else if (busy) begin
      if (pre_q == '0) begin
        pre_d = PRE_W'(TICKS-1);
        us_d  = us_q - 1'b1;
      end else begin
        pre_d = pre_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (load || busy) begin
      pre_q <= pre_d;
      us_q  <= us_d;
    end
  end
endmodule

// File: rtl/bytecmd_bridge.sv
module bytecmd_bridge
  import bcb_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [BYTE_W-1:0]   in_data,
  output logic                in_ready,
  output logic                out_valid,
  output logic [BYTE_W-1:0]   out_data,
  input  logic                out_ready,
  output logic                bus_valid,
  output logic                bus_write,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [WORD_W-1:0]   bus_wdata,
  input  logic                bus_ready,
  input  logic [WORD_W-1:0]   bus_rdata,
  output logic                halted
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  bcb_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              addr_en, wdata_en;

  logic              asm_valid, asm_ready, word_valid, word_take;
  logic [WORD_W-1:0] word_data;
  logic [OP_W-1:0]   hdr_op;
  logic              tx_load, tx_busy;
  logic              tmr_load, tmr_busy;

  assign asm_valid = in_valid && (st_q != ST_HALT);
  assign in_ready  = (st_q == ST_HALT) ? 1'b1 : asm_ready;
  assign hdr_op    = word_data[WORD_W-1 -: OP_W];

  bcb_word_asm #(.BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) i_asm (
    .clk(clk), .rst_n(rst_n_int),
    .byte_valid(asm_valid), .byte_data(in_data), .byte_ready(asm_ready),
    .word_valid(word_valid), .word_data(word_data), .word_take(word_take)
  );

  bcb_byte_ser #(.BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) i_ser (
    .clk(clk), .rst_n(rst_n_int),
    .load(tx_load), .load_word(bus_rdata), .busy(tx_busy),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  bcb_usec_timer #(.CLK_HZ(CLK_HZ), .CNT_W(WORD_W)) i_tmr (
    .clk(clk), .rst_n(rst_n_int),
    .load(tmr_load), .load_us(word_data), .busy(tmr_busy)
  );

  always_comb begin
    st_d      = st_q;
    word_take = 1'b0;
    addr_en   = 1'b0;
    wdata_en  = 1'b0;
    tx_load   = 1'b0;
    tmr_load  = 1'b0;
    unique case (st_q)
      ST_HDR: if (word_valid) begin
        word_take = 1'b1;
        addr_en   = 1'b1;
        case (hdr_op)
          OP_WRITE: st_d = ST_WDATA;
          OP_READ:  st_d = ST_BUSR;
          OP_DELAY: st_d = ST_DDATA;
          default:  st_d = ST_HALT;
        endcase
      end
      ST_WDATA: if (word_valid) begin
        word_take = 1'b1;
        wdata_en  = 1'b1;
        st_d      = ST_BUSW;
      end
      ST_DDATA: if (word_valid) begin
        word_take = 1'b1;
        tmr_load  = 1'b1;
        st_d      = ST_WAIT;
      end
      ST_BUSW: if (bus_ready) st_d = ST_HDR;
      ST_BUSR: if (bus_ready) begin
        tx_load = 1'b1;
        st_d    = ST_SEND;
      end
      ST_SEND: if (!tx_busy)  st_d = ST_HDR;
      ST_WAIT: if (!tmr_busy) st_d = ST_HDR;
      default: st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      st_q    <= ST_HDR;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (addr_en)  addr_q  <= word_data[ADDR_W-1:0];
      if (wdata_en) wdata_q <= word_data;
    end
  end

  assign bus_valid = (st_q == ST_BUSW) || (st_q == ST_BUSR);
  assign bus_write = (st_q == ST_BUSW);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign halted    = (st_q == ST_HALT);
endmodule

// File: rtl/bcb_checker.sv
module bcb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic [7:0]  out_data,
  input logic        out_ready,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [23:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_ready,
  input logic        halted
);
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r7_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable({bus_write, bus_addr, bus_wdata})));

  a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r5_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (in_ready && !bus_valid && !out_valid));

  a_r9_reply_first: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !bus_valid);
endmodule

bind bytecmd_bridge bcb_checker i_bcb_checker (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .out_ready(out_ready), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_ready(bus_ready), .halted(halted)
);

// File: tb/test_bytecmd_bridge.sv
`timescale 1ns/1ps
module test_bytecmd_bridge;
  localparam int CLK_HZ = 200_000_000;
  localparam int TICKS  = CLK_HZ / 1_000_000;

  typedef struct packed {
    logic        wr;
    logic [23:0] a;
    logic [31:0] d;
  } bus_exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready;
  logic        bus_valid, bus_write;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        halted;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic hold_out = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  bus_exp_t   bus_q[$];
  logic [7:0] byte_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rd_fn(input logic [23:0] a);
    return {a[7:0] ^ 8'hA5, a};
  endfunction
  assign bus_rdata = rd_fn(bus_addr);

  bytecmd_bridge #(.CLK_HZ(CLK_HZ)) i_bytecmd_bridge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .halted(halted)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Slave and consumer: ready first, then observe the handshake that the next edge completes
  always @(negedge clk) begin
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bus_ready = lfsr[0] | lfsr[3];
    out_ready = !hold_out && (lfsr[7] | lfsr[2]);
    if (rst_n && bus_valid && bus_ready) begin
      if (bus_q.size() == 0) begin
        check(1'b0, "R2/R3/R5 unexpected bus request", {bus_write, bus_addr}, 64'h0);
      end else begin
        bus_exp_t e;
        e = bus_q.pop_front();
        if (e.wr) check(bus_write && bus_addr == e.a && bus_wdata == e.d, "R2 write",
                        {7'd0, bus_write, bus_addr, bus_wdata}, {7'd0, e.wr, e.a, e.d});
        else      check(!bus_write && bus_addr == e.a, "R3 read request",
                        {bus_write, bus_addr}, {e.wr, e.a});
      end
    end
    if (rst_n && out_valid && out_ready) begin
      if (byte_q.size() == 0) begin
        check(1'b0, "R3/R5 unexpected output byte", out_data, 64'h0);
      end else begin
        logic [7:0] eb;
        eb = byte_q.pop_front();
        check(out_data == eb, "R1/R3 reply byte", out_data, eb);
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
  endtask

  task automatic do_write(input logic [23:0] a, input logic [31:0] d, input logic expect_it);
    if (expect_it) bus_q.push_back({1'b1, a, d});
    send_word({8'h00, a});
    send_word(d);
  endtask

  task automatic do_read(input logic [23:0] a, input logic expect_it);
    logic [31:0] r;
    r = rd_fn(a);
    if (expect_it) begin
      bus_q.push_back({1'b0, a, 32'h0});
      for (int i = 0; i < 4; i++) byte_q.push_back(r[8*i +: 8]);
    end
    send_word({8'h08, a});
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((bus_q.size() != 0 || byte_q.size() != 0) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(bus_q.size() == 0 && byte_q.size() == 0, req, bus_q.size() + byte_q.size(), 0);
  endtask

  task automatic timed_delay(input int us);
    int t0;
    int el;
    send_word({8'h01, 24'h0});
    send_word(us);
    t0 = cyc;
    do_write(24'h000100 + 24'(us), 32'h0BAD_F00D ^ us, 1'b1);
    while (!bus_valid) @(negedge clk);
    el = cyc - t0;
    check(el >= us * TICKS && el <= us * TICKS + 40, "R4 delay length", el, us * TICKS);
  endtask

  task automatic check_reset_state();
    check(!halted, "R8 halted after reset", halted, 0);
    check(!bus_valid, "R8 bus_valid after reset", bus_valid, 0);
    check(!out_valid, "R8 out_valid after reset", out_valid, 0);
    check(in_ready, "R8 in_ready after reset", in_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    bus_ready = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state();

    // R1 R2 R3: mixed writes and reads, byte order covered by distinct byte values
    do_write(24'h123456, 32'hDEAD_BEEF, 1'b1);
    do_read(24'h00ABCD, 1'b1);
    do_write(24'hFFFFFF, 32'h0102_0304, 1'b1);
    do_read(24'hFFFFFF, 1'b1);
    do_read(24'h000000, 1'b1);
    do_write(24'h000000, 32'h0000_0000, 1'b1);
    drain("R2/R3 all commands completed");

    // R4: a three-microsecond pause and a zero pause
    timed_delay(3);
    drain("R4 write after delay");
    timed_delay(0);
    drain("R4 write after zero delay");

    // R6 R9: output held off while a second read waits
    hold_out = 1'b1;
    do_read(24'h5A5A5A, 1'b1);
    do_read(24'h0F0F0F, 1'b1);
    repeat (30) @(negedge clk);
    check(out_valid && out_data == 8'h5A, "R6 byte held under backpressure", {out_valid, out_data}, {1'b1, 8'h5A});
    check(!bus_valid, "R9 no bus request while reply pending", bus_valid, 0);
    hold_out = 1'b0;
    drain("R6 no reply bytes lost");

    // R5: unknown opcode stops the bridge
    send_word({8'h5A, 24'h000001});
    repeat (3) @(negedge clk);
    check(halted, "R5 halted after unknown opcode", halted, 1);
    do_write(24'h000222, 32'h1111_2222, 1'b0);
    do_read(24'h000333, 1'b0);
    check(in_ready, "R5 in_ready while halted", in_ready, 1);
    repeat (20) @(negedge clk);
    check(halted && !bus_valid && !out_valid, "R5 still halted and quiet",
          {halted, bus_valid, out_valid}, 3'b100);

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state();
    do_write(24'h000444, 32'hCAFE_0444, 1'b1);
    do_read(24'h000444, 1'b1);
    drain("R8 commands work after reset");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule